// File: doc/BRIEF.md
# Serial transmit buffer and interrupt controller

This block sits on the transmit side of a framed, multichannel serial port, between the register bus and the shift registers. Software fills a two-word transmit buffer: a low word and a high word. Writing the low word commits both words as one wide entry for the shifter. The block keeps three status flags. The ready flag says the buffer can take new data. The active-low empty flag says the shifter ran dry. The sticky frame-sync-error flag records an unexpected sync. From these flags and from framing events the block raises a one-cycle CPU interrupt pulse and a one-cycle DMA transmit event.

A 2-bit interrupt mode picks the interrupt cause. The four causes are: the ready flag rising, the end of a 16-channel block in multichannel mode, each frame-sync pulse, and the sync-error flag rising. The committed entry goes to the shifter over a valid/ready handshake. `ld_valid` rises once the low word is written. It stays high until the shifter asserts `ld_ready`, and the copy happens on the cycle where both are high. A new low-word write while `ld_valid` is high replaces the pending entry. The shifter may hold `ld_ready` low for as long as it needs. Control and status pins are plain levels or pulses.

Top module: `txbuf_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it, `rdy`, `empty_n`, `sync_err`, `irq`, `dma_evt` and `ld_valid` are all 0, and the interrupt mode is 0.
- R2: A write with `wr_addr`=1 stores the high word and does not raise `ld_valid`. A write with `wr_addr`=0 stores the low word. On the next cycle `ld_valid`=1, `rdy`=0, `empty_n`=1, and `ld_data` = {high word, low word}. If the high word was not written again, its last value is used.
- R3: A cycle with `ld_valid` and `ld_ready` both high, and no low-word write, leaves `ld_valid`=0 and `rdy`=1 on the next cycle.
- R4: `word_done` while `ld_valid` is 0 drives `empty_n` to 0 on the next cycle. While an entry is pending, `empty_n` stays 1.
- R5: Each 0-to-1 change of `rdy` gives a `dma_evt` pulse exactly one cycle wide, one cycle later, in every interrupt mode.
- R6: In mode 0, `irq` pulses for one cycle in the cycle after `rdy` rises, together with `dma_evt`.
- R7: In mode 1, `blk_done` gives an `irq` pulse on the next cycle only when `mc_en`=1. With `mc_en`=0 it gives none.
- R8: In mode 2, every `fsync` pulse gives an `irq` pulse on the next cycle, including while `tx_rst` is held.
- R9: `fsync_err` sets `sync_err` on the next cycle unless `tx_rst` is high. The flag stays set until a control write (`wr_addr`=2) with bit 2 = 0 or a `tx_rst`. Bit 2 = 1 in a control write sets it. A set in the same cycle as a clearing write wins.
- R10: In mode 3, `irq` pulses one cycle after `sync_err` rises. This includes a rise caused by a software write of 1.
- R11: A cycle with `tx_rst` high leaves `sync_err`=0, `rdy`=0, `empty_n`=0 and `ld_valid`=0 on the next cycle.
- R12: A control write takes the interrupt mode from bits 1:0. Writes with `wr_addr`=3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| tx_rst | input | 1 | Synchronous transmitter reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low word, 1 high word, 2 control |
| wr_data | input | WORD_W | Write data; control uses bits 1:0 mode, bit 2 sync error |
| ld_ready | input | 1 | Shifter accepts the committed entry |
| ld_valid | output | 1 | Committed entry waiting for the shifter |
| ld_data | output | 2*WORD_W | {high word, low word} |
| word_done | input | 1 | Shifter finished the current word |
| fsync | input | 1 | Frame-sync pulse detected |
| fsync_err | input | 1 | Unexpected frame-sync detected |
| blk_done | input | 1 | 16-channel block finished |
| mc_en | input | 1 | Multichannel selection mode on |
| rdy | output | 1 | Buffer ready for new data |
| empty_n | output | 1 | 0 when the shifter ran out of data |
| sync_err | output | 1 | Sticky frame-sync error |
| irq_mode | output | 2 | Current interrupt mode |
| irq | output | 1 | Interrupt pulse |
| dma_evt | output | 1 | DMA transmit event pulse |

## Verification
A stuck or stale pending bit shows at once as a wrong `ld_valid`. Within a cycle it also shows as a missing `rdy` rise, and so as a missing `dma_evt` one cycle later. A lost edge-detector history shows as a doubled or missing pulse on `irq` or `dma_evt` two cycles after the flag change. A wrong priority between sync-error set, clear and transmitter reset shows on `sync_err` the cycle after the collision. Comparing every output on every cycle against a behavioural model catches each of these within two cycles of the cause.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    IRQ_ON_READY   = 2'd0,
    IRQ_ON_BLOCK   = 2'd1,
    IRQ_ON_FSYNC   = 2'd2,
    IRQ_ON_SYNCERR = 2'd3
  } irq_mode_e;

  localparam int BUF_WORDS = 2;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam int SERR_BIT  = 2;
endpackage

// File: rtl/txb_buffer.sv
module txb_buffer
  import txb_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        ld_ready,
  input  logic                        word_done,
  output logic                        ld_valid,
  output logic [BUF_WORDS*WORD_W-1:0] ld_data,
  output logic                        rdy,
  output logic                        empty_n
);
  logic commit, take;

  assign commit = wr_en && (wr_addr == ADDR_LO);
  assign take   = ld_valid && ld_ready;

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g)) word_q <= wr_data;
    end
    assign ld_data[g*WORD_W +: WORD_W] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_rst) begin
      ld_valid <= 1'b0;
      rdy      <= 1'b0;
      empty_n  <= 1'b0;
    end else if (commit) begin
      ld_valid <= 1'b1;
      rdy      <= 1'b0;
      empty_n  <= 1'b1;
    end else begin
      if (take) begin
        ld_valid <= 1'b0;
        rdy      <= 1'b1;
      end
      if (word_done && !ld_valid) empty_n <= 1'b0;
    end
  end

  AST_LOW_WRITE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !tx_rst) |=> (ld_valid && !rdy && empty_n)); // R2
  AST_COPY_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !commit && !tx_rst) |=> (rdy && !ld_valid)); // R3
  AST_EMPTY_ON_DRY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !ld_valid && !commit && !tx_rst) |=> !empty_n); // R4
  AST_TXRST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (!rdy && !empty_n && !ld_valid)); // R11
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import txb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_rst,
  input  logic      ctrl_wr,
  input  logic [1:0] ctrl_mode,
  input  logic      ctrl_serr,
  input  logic      fsync_err,
  output irq_mode_e mode,
  output logic      sync_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= IRQ_ON_READY;
      sync_err <= 1'b0;
    end else begin
      if (ctrl_wr) mode <= irq_mode_e'(ctrl_mode);
      if (tx_rst)         sync_err <= 1'b0;
      else if (fsync_err) sync_err <= 1'b1;
      else if (ctrl_wr)   sync_err <= ctrl_serr;
    end
  end

  AST_SERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !tx_rst && !(ctrl_wr && !ctrl_serr)) |=> sync_err); // R9
  AST_SERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_err && !tx_rst) |=> sync_err); // R9
  AST_SERR_TXRST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> !sync_err); // R11
endmodule

// File: rtl/txb_events.sv
module txb_events
  import txb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  logic      rdy,
  input  logic      sync_err,
  input  logic      fsync,
  input  logic      blk_done,
  input  logic      mc_en,
  output logic      irq,
  output logic      dma_evt
);
  localparam int N_FLAGS = 2;
  localparam int F_RDY   = 0;
  localparam int F_SERR  = 1;

  logic [N_FLAGS-1:0] lvl, lvl_q, rise;
  logic               irq_sel;

  assign lvl  = {sync_err, rdy};
  assign rise = lvl & ~lvl_q;

  always_comb begin
    unique case (mode)
      IRQ_ON_READY:   irq_sel = rise[F_RDY];
      IRQ_ON_BLOCK:   irq_sel = blk_done && mc_en;
      IRQ_ON_FSYNC:   irq_sel = fsync;
      IRQ_ON_SYNCERR: irq_sel = rise[F_SERR];
      default:        irq_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      irq     <= 1'b0;
      dma_evt <= 1'b0;
    end else begin
      lvl_q   <= lvl;
      irq     <= irq_sel;
      dma_evt <= rise[F_RDY];
    end
  end

  AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt |=> !dma_evt); // R5
  AST_DMA_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |=> dma_evt); // R5
  AST_IRQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_ON_READY && $rose(rdy)) |=> (irq && dma_evt)); // R6
  AST_IRQ_BLOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_ON_BLOCK && !(blk_done && mc_en)) |=> !irq); // R7
  AST_IRQ_FSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_ON_FSYNC && fsync) |=> irq); // R8
  AST_IRQ_SYNCERR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_ON_SYNCERR && $rose(sync_err)) |=> irq); // R10
endmodule

// File: rtl/txbuf_irq_ctrl.sv
module txbuf_irq_ctrl
  import txb_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_rst,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        ld_ready,
  output logic                        ld_valid,
  output logic [2*WORD_W-1:0]         ld_data,
  input  logic                        word_done,
  input  logic                        fsync,
  input  logic                        fsync_err,
  input  logic                        blk_done,
  input  logic                        mc_en,
  output logic                        rdy,
  output logic                        empty_n,
  output logic                        sync_err,
  output logic [1:0]                  irq_mode,
  output logic                        irq,
  output logic                        dma_evt
);
  irq_mode_e mode;
  logic      ctrl_wr;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign irq_mode = mode;

  txb_buffer #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_ready(ld_ready), .word_done(word_done),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .rdy(rdy), .empty_n(empty_n)
  );

  txb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst),
    .ctrl_wr(ctrl_wr), .ctrl_mode(wr_data[1:0]), .ctrl_serr(wr_data[SERR_BIT]),
    .fsync_err(fsync_err), .mode(mode), .sync_err(sync_err)
  );

  txb_events u_evt (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rdy(rdy), .sync_err(sync_err),
    .fsync(fsync), .blk_done(blk_done), .mc_en(mc_en),
    .irq(irq), .dma_evt(dma_evt)
  );

  AST_MODE_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (irq_mode == $past(wr_data[1:0]))); // R12
endmodule

// File: tb/txbuf_irq_ctrl_test.sv
`timescale 1ns/1ps
module txbuf_irq_ctrl_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tx_rst = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic ld_ready = 1'b0, word_done = 1'b0, fsync = 1'b0, fsync_err = 1'b0;
  logic blk_done = 1'b0, mc_en = 1'b0;
  logic ld_valid, rdy, empty_n, sync_err, irq, dma_evt;
  logic [2*W-1:0] ld_data;
  logic [1:0] irq_mode;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  txbuf_irq_ctrl #(.WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_ready(ld_ready), .ld_valid(ld_valid), .ld_data(ld_data),
    .word_done(word_done), .fsync(fsync), .fsync_err(fsync_err), .blk_done(blk_done),
    .mc_en(mc_en), .rdy(rdy), .empty_n(empty_n), .sync_err(sync_err),
    .irq_mode(irq_mode), .irq(irq), .dma_evt(dma_evt)
  );

  // behavioural reference model
  int m_lo, m_hi, m_mode;
  bit m_pend, m_rdy, m_empty_n, m_serr, m_rdy_old, m_serr_old, m_irq, m_dma;
  string m_irq_tag = "R6";

  always @(posedge clk) begin
    bit wl, wh, wc, take, nirq;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_mode = 0; m_pend = 0; m_rdy = 0; m_empty_n = 0;
      m_serr = 0; m_rdy_old = 0; m_serr_old = 0; m_irq = 0; m_dma = 0;
    end else begin
      wl = wr_en && wr_addr == 0;
      wh = wr_en && wr_addr == 1;
      wc = wr_en && wr_addr == 2;
      take = m_pend && ld_ready;
      case (m_mode)
        0: begin nirq = m_rdy && !m_rdy_old; m_irq_tag = "R6"; end
        1: begin nirq = blk_done && mc_en; m_irq_tag = "R7"; end
        2: begin nirq = fsync; m_irq_tag = "R8"; end
        default: begin nirq = m_serr && !m_serr_old; m_irq_tag = "R10"; end
      endcase
      m_dma = m_rdy && !m_rdy_old;
      m_irq = nirq;
      m_rdy_old = m_rdy;
      m_serr_old = m_serr;
      if (wl) m_lo = int'(wr_data);
      if (wh) m_hi = int'(wr_data);
      if (tx_rst) begin
        m_pend = 0; m_rdy = 0; m_empty_n = 0; m_serr = 0;
      end else begin
        if (wl) begin m_pend = 1; m_rdy = 0; m_empty_n = 1; end
        else begin
          if (word_done && !m_pend) m_empty_n = 0;
          if (take) begin m_pend = 0; m_rdy = 1; end
        end
        if (fsync_err) m_serr = 1;
        else if (wc) m_serr = wr_data[2];
      end
      if (wc) m_mode = int'(wr_data[1:0]);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2", "ld_valid", ld_valid, m_pend);
      if (m_pend) chk("R2", "ld_data", ld_data, {m_hi[15:0], m_lo[15:0]});
      chk("R3", "rdy", rdy, m_rdy);
      chk("R4", "empty_n", empty_n, m_empty_n);
      chk("R9", "sync_err", sync_err, m_serr);
      chk("R5", "dma_evt", dma_evt, m_dma);
      chk(m_irq_tag, "irq", irq, m_irq);
      chk("R12", "irq_mode", irq_mode, m_mode);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    // R1 reset state
    chk("R1", "rdy", rdy, 0);
    chk("R1", "empty_n", empty_n, 0);
    chk("R1", "sync_err", sync_err, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "dma_evt", dma_evt, 0);
    chk("R1", "ld_valid", ld_valid, 0);
    chk("R1", "irq_mode", irq_mode, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "ld_valid after release", ld_valid, 0);
    cmp_on = 1'b1;

    // R2 ordered load, mode 0
    wr(2'd1, 16'h1234);
    chk("R2", "high write no commit", ld_valid, 0);
    wr(2'd0, 16'hABCD);
    chk("R2", "commit data", ld_data, 32'h1234ABCD);
    chk("R2", "empty_n after commit", empty_n, 1);
    // R3 copy, R5/R6 pulses
    ld_ready = 1'b1; idle(1); ld_ready = 1'b0;
    chk("R3", "rdy after copy", rdy, 1);
    idle(1);
    chk("R5", "dma pulse", dma_evt, 1);
    chk("R6", "irq mode0", irq, 1);
    idle(1);
    chk("R5", "dma one cycle", dma_evt, 0);
    // R4 dry shifter
    word_done = 1'b1; idle(1); word_done = 1'b0;
    chk("R4", "empty_n dry", empty_n, 0);
    // R2 stale high word reused
    wr(2'd0, 16'h5555);
    chk("R2", "stale high", ld_data, 32'h12345555);
    wr(2'd3, 16'h0003);
    chk("R12", "addr 3 ignored", irq_mode, 0);

    // R7 mode 1
    wr(2'd2, 16'h0001);
    mc_en = 1'b0; blk_done = 1'b1; idle(1); blk_done = 1'b0;
    chk("R7", "no irq mc off", irq, 0);
    mc_en = 1'b1; blk_done = 1'b1; idle(1); blk_done = 1'b0;
    chk("R7", "irq mc on", irq, 1);
    ld_ready = 1'b1; idle(1); ld_ready = 1'b0; idle(1);
    chk("R7", "ready rise no irq", irq, 0);
    chk("R5", "dma in mode1", dma_evt, 1);

    // R8 mode 2 under transmitter reset
    wr(2'd2, 16'h0002);
    tx_rst = 1'b1; idle(1);
    fsync = 1'b1; idle(1); fsync = 1'b0;
    chk("R8", "irq in tx reset", irq, 1);
    tx_rst = 1'b0; idle(1);

    // R9/R10 mode 3
    wr(2'd2, 16'h0003);
    fsync_err = 1'b1; idle(1); fsync_err = 1'b0;
    chk("R9", "serr set", sync_err, 1);
    idle(1);
    chk("R10", "irq on serr", irq, 1);
    idle(3);
    chk("R9", "serr sticky", sync_err, 1);
    fsync_err = 1'b1; wr(2'd2, 16'h0003); fsync_err = 1'b0;
    chk("R9", "set wins over clear", sync_err, 1);
    wr(2'd2, 16'h0003);
    chk("R9", "serr cleared", sync_err, 0);
    wr(2'd2, 16'h0007);
    chk("R9", "serr sw set", sync_err, 1);
    idle(1);
    chk("R10", "irq sw set", irq, 1);

    // R11 transmitter reset
    wr(2'd0, 16'h0F0F);
    tx_rst = 1'b1; idle(1); tx_rst = 1'b0;
    chk("R11", "serr", sync_err, 0);
    chk("R11", "rdy", rdy, 0);
    chk("R11", "empty_n", empty_n, 0);
    chk("R11", "ld_valid", ld_valid, 0);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      wr_en     = ($urandom % 4) == 0;
      wr_addr   = 2'($urandom % 4);
      wr_data   = W'($urandom);
      ld_ready  = ($urandom % 3) == 0;
      word_done = ($urandom % 4) == 0;
      fsync     = ($urandom % 6) == 0;
      fsync_err = ($urandom % 20) == 0;
      blk_done  = ($urandom % 5) == 0;
      tx_rst    = ($urandom % 60) == 0;
      if (i % 64 == 0) mc_en = $urandom % 2;
      idle(1);
    end
    wr_en = 0; ld_ready = 0; word_done = 0; fsync = 0; fsync_err = 0;
    blk_done = 0; tx_rst = 0;
    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule